// File: doc/BRIEF.md
# Program-Check Trap Entry Unit

This block sits beside the execute stage of a simple in-order core and decides whether the instruction being issued must enter the program-check exception. Each issue presents the instruction address, the live machine state register (MSR), a small operation-class code, the top bit of the special-register number field, and a flag from the decoder saying the opcode is illegal. From these the unit works out whether the instruction is privileged. It traps when a privileged instruction runs in problem state, and it also traps on any illegal opcode.

When a trap fires, the unit blocks the faulting instruction's register writeback in the same cycle. On the next clock edge it updates several registers. The first save register takes the instruction address. The second save register takes a copy of the MSR with a cause bit set in it. It also rewrites the MSR to a fixed supervisor image and redirects the next program counter to the program-check vector. A one-cycle pulse marks trap entry. When an issue does not trap, the next program counter is simply the sequential address, and the save registers and MSR image keep their values.

Top module: `prog_check_entry`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `trap_taken`, `pc_update` and `msr_we` are 0, and `next_pc`, `msr_new`, `save_pc` and `save_msr` are all zero.
- R2: Class codes 1 (read MSR), 2 (write MSR), 3 (attention) and 4 (return from interrupt) are always privileged. Codes 5 (read special register) and 6 (write special register) are privileged only when `issue_spr_hi` is 1. Codes 0 and 7 are never privileged.
- R3: A privileged instruction traps only when the problem-state bit, bit 14 of `cur_msr`, is 1. With bit 14 at 0 and no illegal flag, it does not trap.
- R4: An issue with `issue_illegal` set traps whatever the value of bit 14. When the privilege condition and the illegal flag hold together, the trap cause is privileged.
- R5: On a trap, `save_pc` takes `issue_cia`. `save_msr` takes `cur_msr` with bits 19 and 18 cleared, and then bit 18 set for a privileged cause or bit 19 set for an illegal cause. When an issue does not trap, both save registers keep their values.
- R6: On a trap, `msr_new` takes `cur_msr` with bits 1, 2, 4, 5, 6, 8, 9, 10, 11, 13, 14, 15, 23, 25 and 32 cleared and bits 63 and 0 set, and `msr_we` pulses for one cycle. The reason bits 18 and 19 of `cur_msr` pass through unchanged. When an issue does not trap, `msr_new` holds its value.
- R7: In the cycle after every accepted issue, `pc_update` is 1. `next_pc` is then 0x700 if that issue trapped, or `issue_cia` + 4 if it did not.
- R8: `trap_taken` is 1 in exactly the cycle after each trapping issue, and 0 in the cycle after an idle cycle or a non-trapping issue.
- R9: `wb_commit` equals `issue_valid & wb_req & ~trap` in the same cycle, so a trapping instruction writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_cia | input | 64 | Address of the presented instruction |
| issue_class | input | 3 | Operation class code (see R2) |
| issue_spr_hi | input | 1 | Top bit of the special-register number field |
| issue_illegal | input | 1 | Decoder found no legal opcode |
| cur_msr | input | 64 | Live machine state register |
| wb_req | input | 1 | Instruction wants to write its results |
| wb_commit | output | 1 | Writeback allowed (combinational) |
| trap_taken | output | 1 | One-cycle trap entry pulse |
| pc_update | output | 1 | `next_pc` is valid this cycle |
| next_pc | output | 64 | Redirect or sequential address |
| msr_we | output | 1 | Write `msr_new` into the live MSR |
| msr_new | output | 64 | Supervisor MSR image |
| save_pc | output | 64 | Saved return address |
| save_msr | output | 64 | Saved MSR with cause bit |

## Verification
`wb_commit` is combinational and is due in the same cycle as the issue. The bench drives inputs on the falling edge and reads it one time unit later. All other results are registered once and are due in the cycle after the issue. The bench therefore drops `issue_valid` on the next falling edge and reads the pulses, `next_pc`, the MSR image and the save registers at that point. It then waits one more falling edge and confirms that the pulses have cleared. The sweep covers every combination of class code, field bit, problem state, illegal flag and writeback request. A back-to-back pair of trapping issues checks that each trap's results land in its own following cycle.

// File: rtl/prog_check_pkg.sv
package prog_check_pkg;

    localparam int XLEN = 64;

    // MSR bit positions, bit 0 = least significant
    localparam int MSR_LE  = 0;
    localparam int MSR_RI  = 1;
    localparam int MSR_PMM = 2;
    localparam int MSR_DR  = 4;
    localparam int MSR_IR  = 5;
    localparam int MSR_RSV = 6;
    localparam int MSR_FE1 = 8;
    localparam int MSR_TE1 = 9;
    localparam int MSR_TE0 = 10;
    localparam int MSR_FE0 = 11;
    localparam int MSR_FP  = 13;
    localparam int MSR_PR  = 14;
    localparam int MSR_EE  = 15;
    localparam int MSR_VSX = 23;
    localparam int MSR_VEC = 25;
    localparam int MSR_TM  = 32;
    localparam int MSR_SF  = 63;

    // cause bits placed only in the saved MSR copy
    localparam int SAVE_PRIV_BIT = 18;
    localparam int SAVE_ILL_BIT  = 19;

    typedef enum logic [2:0] {
        OPC_PLAIN    = 3'd0,
        OPC_READ_MSR = 3'd1,
        OPC_WRITE_MSR= 3'd2,
        OPC_ATTN     = 3'd3,
        OPC_RET_INT  = 3'd4,
        OPC_READ_SPR = 3'd5,
        OPC_WRITE_SPR= 3'd6,
        OPC_SPARE    = 3'd7
    } op_class_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_PRIV    = 2'd1,
        CAUSE_ILLEGAL = 2'd2
    } trap_cause_e;

    typedef struct packed {
        logic        fire;
        trap_cause_e cause;
    } trap_req_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] msr;
    } save_pair_t;

    function automatic logic [XLEN-1:0] entry_clear_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[MSR_RI]  = 1'b1;
        m[MSR_PMM] = 1'b1;
        m[MSR_DR]  = 1'b1;
        m[MSR_IR]  = 1'b1;
        m[MSR_RSV] = 1'b1;
        m[MSR_FE1] = 1'b1;
        m[MSR_TE1] = 1'b1;
        m[MSR_TE0] = 1'b1;
        m[MSR_FE0] = 1'b1;
        m[MSR_FP]  = 1'b1;
        m[MSR_PR]  = 1'b1;
        m[MSR_EE]  = 1'b1;
        m[MSR_VSX] = 1'b1;
        m[MSR_VEC] = 1'b1;
        m[MSR_TM]  = 1'b1;
        return m;
    endfunction

    function automatic logic [XLEN-1:0] entry_set_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[MSR_SF] = 1'b1;
        m[MSR_LE] = 1'b1;
        return m;
    endfunction

    function automatic logic [XLEN-1:0] msr_entry_image(input logic [XLEN-1:0] msr);
        return (msr & ~entry_clear_mask()) | entry_set_mask();
    endfunction

    function automatic logic [XLEN-1:0] save_msr_image(input logic [XLEN-1:0] msr,
                                                       input trap_cause_e cause);
        logic [XLEN-1:0] v;
        v = msr;
        v[SAVE_PRIV_BIT] = (cause == CAUSE_PRIV);
        v[SAVE_ILL_BIT]  = (cause == CAUSE_ILLEGAL);
        return v;
    endfunction

endpackage

// File: rtl/opclass_priv_check.sv
module opclass_priv_check
    import prog_check_pkg::*;
(
    input  op_class_e cls,
    input  logic      spr_hi,
    output logic      is_priv
);
    always_comb begin
        unique case (cls)
            OPC_READ_MSR, OPC_WRITE_MSR, OPC_ATTN, OPC_RET_INT: is_priv = 1'b1;
            OPC_READ_SPR, OPC_WRITE_SPR:                         is_priv = spr_hi;
            default:                                             is_priv = 1'b0;
        endcase
    end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import prog_check_pkg::*;
(
    input  logic      valid,
    input  logic      is_priv,
    input  logic      problem_state,
    input  logic      illegal,
    output trap_req_t req
);
    logic priv_hit;
    assign priv_hit = is_priv & problem_state;

    always_comb begin
        req.fire  = 1'b0;
        req.cause = CAUSE_NONE;
        if (valid) begin
            if (priv_hit) begin
                req.fire  = 1'b1;
                req.cause = CAUSE_PRIV;
            end else if (illegal) begin
                req.fire  = 1'b1;
                req.cause = CAUSE_ILLEGAL;
            end
        end
    end
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
    import prog_check_pkg::*;
#(
    parameter logic [XLEN-1:0] TRAP_VECTOR = 64'h700,
    parameter int unsigned     INSN_BYTES  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  trap_req_t       req,
    input  logic [XLEN-1:0] cia,
    input  logic [XLEN-1:0] msr_in,
    output logic            trap_pulse,
    output logic            pc_upd,
    output logic [XLEN-1:0] npc,
    output logic            msr_wr,
    output logic [XLEN-1:0] msr_img,
    output save_pair_t      saved
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_pulse <= 1'b0;
            pc_upd     <= 1'b0;
            npc        <= '0;
            msr_wr     <= 1'b0;
            msr_img    <= '0;
            saved      <= '0;
        end else begin
            trap_pulse <= req.fire;
            msr_wr     <= req.fire;
            pc_upd     <= valid;
            if (valid) begin
                npc <= req.fire ? TRAP_VECTOR : cia + STEP;
            end
            if (req.fire) begin
                msr_img   <= msr_entry_image(msr_in);
                saved.pc  <= cia;
                saved.msr <= save_msr_image(msr_in, req.cause);
            end
        end
    end
endmodule

// File: rtl/prog_check_entry.sv
module prog_check_entry
    import prog_check_pkg::*;
#(
    parameter logic [63:0] TRAP_VECTOR = 64'h700,
    parameter int unsigned INSN_BYTES  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_valid,
    input  logic [63:0] issue_cia,
    input  logic [2:0]  issue_class,
    input  logic        issue_spr_hi,
    input  logic        issue_illegal,
    input  logic [63:0] cur_msr,
    input  logic        wb_req,
    output logic        wb_commit,
    output logic        trap_taken,
    output logic        pc_update,
    output logic [63:0] next_pc,
    output logic        msr_we,
    output logic [63:0] msr_new,
    output logic [63:0] save_pc,
    output logic [63:0] save_msr
);
    logic       is_priv;
    trap_req_t  req;
    save_pair_t saved;

    opclass_priv_check u_cls (
        .cls     (op_class_e'(issue_class)),
        .spr_hi  (issue_spr_hi),
        .is_priv (is_priv)
    );

    trap_arbiter u_arb (
        .valid         (issue_valid),
        .is_priv       (is_priv),
        .problem_state (cur_msr[MSR_PR]),
        .illegal       (issue_illegal),
        .req           (req)
    );

    trap_state_regs #(
        .TRAP_VECTOR (TRAP_VECTOR),
        .INSN_BYTES  (INSN_BYTES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .valid      (issue_valid),
        .req        (req),
        .cia        (issue_cia),
        .msr_in     (cur_msr),
        .trap_pulse (trap_taken),
        .pc_upd     (pc_update),
        .npc        (next_pc),
        .msr_wr     (msr_we),
        .msr_img    (msr_new),
        .saved      (saved)
    );

    assign wb_commit = issue_valid & wb_req & ~req.fire;
    assign save_pc   = saved.pc;
    assign save_msr  = saved.msr;
endmodule

// File: rtl/prog_check_entry_chk.sv
module prog_check_entry_chk
    import prog_check_pkg::*;
#(
    parameter logic [63:0] TRAP_VECTOR = 64'h700
) (
    input logic        clk,
    input logic        rst,
    input logic        issue_valid,
    input logic [63:0] issue_cia,
    input logic        issue_illegal,
    input logic        wb_req,
    input logic        wb_commit,
    input logic        trap_taken,
    input logic        pc_update,
    input logic [63:0] next_pc,
    input logic        msr_we,
    input logic [63:0] msr_new,
    input logic [63:0] save_pc,
    input logic [63:0] save_msr
);
    a_r8_pulse_follows_issue: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> $past(issue_valid));

    a_r7_vector_redirect: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> (pc_update && next_pc == TRAP_VECTOR));

    a_r6_supervisor_image: assert property (@(posedge clk) disable iff (rst)
        msr_we |-> (!msr_new[MSR_PR] && !msr_new[MSR_EE] && msr_new[MSR_SF] && msr_new[MSR_LE]));

    a_r5_save_address: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> (save_pc == $past(issue_cia)));

    a_r5_single_cause: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> ($countones({save_msr[SAVE_ILL_BIT], save_msr[SAVE_PRIV_BIT]}) == 1));

    a_r5_save_hold: assert property (@(posedge clk) disable iff (rst)
        !trap_taken |-> ($stable(save_pc) && $stable(save_msr)));

    a_r9_commit_needs_request: assert property (@(posedge clk) disable iff (rst)
        wb_commit |-> (issue_valid && wb_req));

    a_r4_illegal_kills_writeback: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_illegal) |-> !wb_commit);
endmodule

bind prog_check_entry prog_check_entry_chk #(.TRAP_VECTOR(TRAP_VECTOR)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .issue_valid   (issue_valid),
    .issue_cia     (issue_cia),
    .issue_illegal (issue_illegal),
    .wb_req        (wb_req),
    .wb_commit     (wb_commit),
    .trap_taken    (trap_taken),
    .pc_update     (pc_update),
    .next_pc       (next_pc),
    .msr_we        (msr_we),
    .msr_new       (msr_new),
    .save_pc       (save_pc),
    .save_msr      (save_msr)
);

// File: tb/prog_check_entry_test.sv
`timescale 1ns/1ps
module prog_check_entry_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [63:0] issue_cia;
    logic [2:0]  issue_class;
    logic        issue_spr_hi;
    logic        issue_illegal;
    logic [63:0] cur_msr;
    logic        wb_req;
    logic        wb_commit, trap_taken, pc_update, msr_we;
    logic [63:0] next_pc, msr_new, save_pc, save_msr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prog_check_entry uut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_cia(issue_cia),
        .issue_class(issue_class), .issue_spr_hi(issue_spr_hi),
        .issue_illegal(issue_illegal), .cur_msr(cur_msr), .wb_req(wb_req),
        .wb_commit(wb_commit), .trap_taken(trap_taken), .pc_update(pc_update),
        .next_pc(next_pc), .msr_we(msr_we), .msr_new(msr_new),
        .save_pc(save_pc), .save_msr(save_msr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // supervisor image computed from the requirement's own bit lists
    function automatic logic [63:0] exp_image(input logic [63:0] m);
        int clr[15] = '{1, 2, 4, 5, 6, 8, 9, 10, 11, 13, 14, 15, 23, 25, 32};
        logic [63:0] v = m;
        foreach (clr[k]) v[clr[k]] = 1'b0;
        v[63] = 1'b1;
        v[0]  = 1'b1;
        return v;
    endfunction

    logic [63:0] e_save_pc, e_save_msr, e_msr_new, e_npc;

    task automatic issue_and_check(input int cls, input bit hi, input bit pr,
                                   input bit ill, input bit wr,
                                   input logic [63:0] cia, input logic [63:0] msr_base);
        bit priv, fire, pcause;
        logic [63:0] m;
        m = msr_base;
        m[14] = pr;
        priv   = (cls >= 1 && cls <= 4) || ((cls == 5 || cls == 6) && hi);
        pcause = priv && pr;
        fire   = pcause || ill;
        issue_valid   = 1'b1;
        issue_class   = 3'(cls);
        issue_spr_hi  = hi;
        issue_illegal = ill;
        issue_cia     = cia;
        cur_msr       = m;
        wb_req        = wr;
        #1;
        check(wb_commit == (wr && !fire), "R9 writeback gate", 64'(wb_commit), 64'(wr && !fire));
        @(negedge clk);
        issue_valid = 1'b0;
        if (fire) begin
            e_save_pc  = cia;
            e_save_msr = m;
            e_save_msr[18] = pcause;
            e_save_msr[19] = !pcause;
            e_msr_new  = exp_image(m);
            e_npc      = 64'h700;
        end else begin
            e_npc = cia + 64'd4;
        end
        check(trap_taken == fire, pcause ? "R3 privileged trap" : (ill ? "R4 illegal trap" : "R2 no trap"),
              64'(trap_taken), 64'(fire));
        check(pc_update === 1'b1, "R7 pc_update", 64'(pc_update), 64'd1);
        check(next_pc == e_npc, "R7 next_pc", next_pc, e_npc);
        check(msr_we == fire, "R6 msr_we", 64'(msr_we), 64'(fire));
        check(msr_new == e_msr_new, "R6 msr_new", msr_new, e_msr_new);
        check(save_pc == e_save_pc, "R5 save_pc", save_pc, e_save_pc);
        check(save_msr == e_save_msr, "R5 save_msr", save_msr, e_save_msr);
        @(negedge clk);
        check(!trap_taken && !pc_update && !msr_we, "R8 pulse ends", 64'({trap_taken, pc_update, msr_we}), 64'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        issue_valid = 0; issue_cia = '0; issue_class = '0; issue_spr_hi = 0;
        issue_illegal = 0; cur_msr = '0; wb_req = 0;
        e_save_pc = '0; e_save_msr = '0; e_msr_new = '0; e_npc = '0;
        repeat (3) @(negedge clk);
        check({trap_taken, pc_update, msr_we} == 3'b0, "R1 reset pulses", 64'({trap_taken, pc_update, msr_we}), 64'd0);
        check((next_pc | msr_new | save_pc | save_msr) == 64'd0, "R1 reset registers",
              next_pc | msr_new | save_pc | save_msr, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check({trap_taken, pc_update, msr_we} == 3'b0, "R1 after reset", 64'({trap_taken, pc_update, msr_we}), 64'd0);
        check(wb_commit == 1'b0, "R9 idle no commit", 64'(wb_commit), 64'd0);

        // full sweep: class x field bit x problem state x illegal x writeback
        for (int idx = 0; idx < 128; idx++) begin
            logic [63:0] base;
            base = 64'hDEAD_BEEF_0F0F_F0F0 ^ (64'h0123_4567_89AB_CDEF * 64'(idx));
            issue_and_check(idx & 7, idx[3], idx[4], idx[5], idx[6],
                            64'h0000_4000_0000_1000 + 64'(idx * 8), base);
        end

        // back-to-back traps: second issue follows directly
        issue_valid = 1; issue_class = 3'd3; issue_spr_hi = 0; issue_illegal = 0;
        issue_cia = 64'hAAAA_0000_0000_0010; cur_msr = 64'h0000_0000_000C_4000; wb_req = 1;
        @(negedge clk);
        check(trap_taken && save_msr[18] && !save_msr[19], "R5 first of pair cause", save_msr, 64'h0);
        issue_class = 3'd0; issue_illegal = 1; issue_cia = 64'hBBBB_0000_0000_0020;
        cur_msr = 64'hFFFF_FFFF_FFFF_FFFF;
        #1;
        check(wb_commit == 1'b0, "R9 illegal blocks commit", 64'(wb_commit), 64'd0);
        @(negedge clk);
        issue_valid = 0;
        check(trap_taken == 1'b1, "R8 second pulse", 64'(trap_taken), 64'd1);
        check(save_pc == 64'hBBBB_0000_0000_0020, "R5 second save_pc", save_pc, 64'hBBBB_0000_0000_0020);
        check(save_msr == 64'hFFFF_FFFF_FFFB_FFFF, "R5 illegal cause bits", save_msr, 64'hFFFF_FFFF_FFFB_FFFF);
        check(msr_new == exp_image(64'hFFFF_FFFF_FFFF_FFFF), "R6 all-ones input", msr_new,
              exp_image(64'hFFFF_FFFF_FFFF_FFFF));
        @(negedge clk);
        check(!trap_taken, "R8 pair ends", 64'(trap_taken), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule